// File: doc/BRIEF.md
# Serial Flash Bank Address Register Controller

This block is the device-side logic that owns the bank address register of a serial NOR flash. It runs on a fast internal clock and oversamples the SPI pins: serial clock, active-low chip select and serial data in. It decodes one command byte for each chip-select frame and supports three paths. A direct write loads the register from one data byte. A direct read shifts the register out on SO. A legacy path has two steps: an arming command, then a following register-write command that is redirected to the low bank bits. The register's top bit enables extended (4-byte) addressing. The block forms the effective 32-bit address from a 3-byte command address.

SPI mode 0 is used. SI is captured on the rising SCK edge and SO changes on the falling edge. Bytes go MSB first. SO is enabled only while chip select is low. The busy, program-error and erase-error inputs come from the rest of the flash. The caller drives busy low while an embedded operation is suspended. Write bits 6 down to `BANK_BITS` of the register as 0. They are not stored and always read as 0.

The control state machine has seven states:
- `ST_IDLE`: chip select is high.
- `ST_OPCODE`: collecting the command byte.
- `ST_BANK_WR`: waiting for the direct-write data byte.
- `ST_BANK_RD`: streaming the register out.
- `ST_ARM_WAIT`: the arming opcode has been received and the block waits for chip select to rise.
- `ST_LEG_WR`: waiting for the redirected data byte.
- `ST_SKIP`: ignoring the rest of the frame.

Transitions:
- Chip select going low moves `ST_IDLE` to `ST_OPCODE`.
- A completed opcode selects the next state: 17h goes to `ST_BANK_WR`, 16h to `ST_BANK_RD`, B9h to `ST_ARM_WAIT`. 01h goes to `ST_LEG_WR` while armed and to `ST_SKIP` otherwise. Any other opcode goes to `ST_SKIP`.
- A completed data byte moves `ST_BANK_WR` and `ST_LEG_WR` to `ST_SKIP`.
- Any extra rising SCK edge moves `ST_ARM_WAIT` to `ST_SKIP`.
- Chip select high returns every state to `ST_IDLE`.

Top module: `bankreg_ctrl`

## Requirements
- R1: Reset (rst_n low) clears the bank register to 00h and clears the armed flag. so_oe is high exactly while cs_n is low, and so is 0 when no read is in progress.
- R2: Opcode 17h followed by one data byte loads the register. Bit 7 and bits [BANK_BITS-1:0] take the data value, and all other bits stay 0. No write-enable is needed and the status inputs have no effect. Further bytes in the same frame are ignored.
- R3: Opcode 16h shifts the register out on so, MSB first, one bit per falling SCK edge. The first bit is valid before the first data rising edge, and the byte repeats while clocks continue.
- R4: ext_addr_en equals register bit 7. eff_addr[23:0] equals cmd_addr. eff_addr[31:24] is the register's bits [BANK_BITS-1:0] (zero-extended) when ext_addr_en is 0, and 00h when it is 1.
- R5: A frame holding exactly the 8 bits of opcode B9h sets the armed flag when chip select rises, provided busy, prog_err and erase_err are all low at that moment. One or more extra SCK bits in that frame prevent arming.
- R6: While armed, an 01h frame copies bits [1:0] of its first data byte into register bits [1:0] and clears armed when that byte completes. Bit 7 and the other bits are unchanged, and a second data byte is ignored.
- R7: While armed, any opcode other than 01h clears armed as soon as the opcode byte completes, and that command then behaves normally.
- R8: While armed, a frame that ends before an opcode completes, or an 01h frame that ends before its data byte completes, clears armed without changing the register.
- R9: B9h does not arm while busy, prog_err or erase_err is high. An armed 01h data byte that completes while any of them is high leaves the register unchanged and still clears armed.
- R10: If chip select rises before all 8 bits of a data byte arrive, that byte has no effect on the register.
- R11: An 01h frame while not armed leaves the register unchanged.
- R12: The register never changes while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| busy | input | 1 | Embedded program or erase running (low while suspended) |
| prog_err | input | 1 | Program error flag |
| erase_err | input | 1 | Erase error flag |
| cmd_addr | input | 24 | Address bytes from a 3-byte-address command |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so (low means high-impedance) |
| bank_reg | output | 8 | Current bank register value |
| ext_addr_en | output | 1 | Extended addressing enabled |
| armed | output | 1 | Next 01h command is redirected to the bank register |
| eff_addr | output | 32 | Effective address |

## Verification
The direct write is tried with data values that set all bits, only reserved bits, and mixed bits. This separates correct masking from plain storage. The legacy path runs after each kind of frame that can follow arming: a register write, a different command, an empty frame and a short frame. It also runs with the arming frame over-clocked and with each status flag raised. This separates the one-shot disarm conditions from one another. Reads cover two repeated bytes, to show both bit order and wraparound. A reference model in the bench predicts register, flag and address values and compares them every clock.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OP_BANK_WR = 8'h17;
    localparam logic [BYTE_W-1:0] OP_BANK_RD = 8'h16;
    localparam logic [BYTE_W-1:0] OP_ARM     = 8'hB9;
    localparam logic [BYTE_W-1:0] OP_REG_WR  = 8'h01;

    localparam logic [BYTE_W-1:0] LEG_MASK   = 8'h03;
    localparam logic [BYTE_W-1:0] EXT_MASK   = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_BANK_WR,
        ST_BANK_RD,
        ST_ARM_WAIT,
        ST_LEG_WR,
        ST_SKIP
    } bank_state_t;

endpackage

// File: rtl/bankreg_rx.sv
module bankreg_rx
    import bankreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              sck_rise,
    output logic              sck_fall,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic                 sck_q;
    logic [BYTE_W-2:0]    shift_q;
    logic [BIT_CNT_W-1:0] cnt_q;

    // Edges are qualified by chip select so that idle clocks do nothing.
    assign sck_rise  = ~cs_n & sck & ~sck_q;
    assign sck_fall  = ~cs_n & ~sck & sck_q;
    assign byte_done = sck_rise && (cnt_q == LAST_BIT);
    assign rx_byte   = {shift_q, si};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            shift_q <= '0;
            cnt_q   <= '0;
        end else begin
            sck_q <= sck;
            if (cs_n) begin
                cnt_q <= '0;
            end else if (sck_rise) begin
                shift_q <= {shift_q[BYTE_W-3:0], si};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bankreg_fsm.sv
module bankreg_fsm
    import bankreg_pkg::*;
#(
    parameter int BANK_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              busy,
    input  logic              prog_err,
    input  logic              erase_err,
    output logic [BYTE_W-1:0] bank_reg,
    output logic              armed,
    output logic              rd_start,
    output logic              rd_active
);

    localparam logic [BYTE_W-1:0] LOW_MASK = BYTE_W'((1 << BANK_BITS) - 1);
    localparam logic [BYTE_W-1:0] WR_MASK  = EXT_MASK | LOW_MASK;
    localparam logic [BYTE_W-1:0] LEG_WR_MASK = LEG_MASK & WR_MASK;

    bank_state_t state_q, state_d;
    logic        allowed;
    logic        op_done;

    assign allowed = ~(busy | prog_err | erase_err);
    assign op_done = (state_q == ST_OPCODE) && byte_done;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_n) state_d = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (byte_done) begin
                    if (rx_byte == OP_BANK_WR)      state_d = ST_BANK_WR;
                    else if (rx_byte == OP_BANK_RD) state_d = ST_BANK_RD;
                    else if (rx_byte == OP_ARM)     state_d = ST_ARM_WAIT;
                    else if (rx_byte == OP_REG_WR)  state_d = armed ? ST_LEG_WR : ST_SKIP;
                    else                            state_d = ST_SKIP;
                end
            end
            ST_BANK_WR: begin
                if (byte_done) state_d = ST_SKIP;
            end
            ST_BANK_RD: begin
                state_d = ST_BANK_RD;
            end
            ST_ARM_WAIT: begin
                if (sck_rise) state_d = ST_SKIP;
            end
            ST_LEG_WR: begin
                if (byte_done) state_d = ST_SKIP;
            end
            ST_SKIP: begin
                state_d = ST_SKIP;
            end
            default: state_d = ST_IDLE;
        endcase
        if (cs_n) state_d = ST_IDLE;
    end

    // Register and one-shot flag updates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_reg <= '0;
            armed    <= 1'b0;
        end else if (cs_n) begin
            if (state_q != ST_IDLE) armed <= (state_q == ST_ARM_WAIT) && allowed;
        end else if (op_done) begin
            if (rx_byte != OP_REG_WR) armed <= 1'b0;
        end else if (byte_done && (state_q == ST_BANK_WR)) begin
            bank_reg <= rx_byte & WR_MASK;
        end else if (byte_done && (state_q == ST_LEG_WR)) begin
            armed <= 1'b0;
            if (allowed) bank_reg <= (bank_reg & ~LEG_WR_MASK) | (rx_byte & LEG_WR_MASK);
        end
    end

    assign rd_start  = op_done && (rx_byte == OP_BANK_RD);
    assign rd_active = (state_q == ST_BANK_RD);

endmodule

// File: rtl/bankreg_tx.sv
module bankreg_tx
    import bankreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              rd_active,
    input  logic              sck_fall,
    input  logic [BYTE_W-1:0] bank_reg,
    output logic              so
);

    logic [BIT_CNT_W-1:0] idx_q;
    logic                 so_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            so_q  <= 1'b0;
        end else if (rd_start) begin
            idx_q <= '0;
            so_q  <= 1'b0;
        end else if (rd_active && sck_fall) begin
            // Index counts up; the inverted index walks bits MSB first and wraps.
            so_q  <= bank_reg[~idx_q];
            idx_q <= idx_q + 1'b1;
        end
    end

    assign so = rd_active & so_q;

endmodule

// File: rtl/bankreg_addr_map.sv
module bankreg_addr_map
    import bankreg_pkg::*;
#(
    parameter int BANK_BITS = 2,
    parameter int ADDR_W    = 24
) (
    input  logic [BYTE_W-1:0]        bank_reg,
    input  logic [ADDR_W-1:0]        cmd_addr,
    output logic                     ext_addr_en,
    output logic [ADDR_W+BYTE_W-1:0] eff_addr
);

    localparam logic [BYTE_W-1:0] LOW_MASK = BYTE_W'((1 << BANK_BITS) - 1);

    assign ext_addr_en = bank_reg[BYTE_W-1];
    assign eff_addr    = {ext_addr_en ? {BYTE_W{1'b0}} : (bank_reg & LOW_MASK), cmd_addr};

endmodule

// File: rtl/bankreg_ctrl.sv
module bankreg_ctrl
    import bankreg_pkg::*;
#(
    parameter int BANK_BITS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck,
    input  logic        cs_n,
    input  logic        si,
    input  logic        busy,
    input  logic        prog_err,
    input  logic        erase_err,
    input  logic [23:0] cmd_addr,
    output logic        so,
    output logic        so_oe,
    output logic [7:0]  bank_reg,
    output logic        ext_addr_en,
    output logic        armed,
    output logic [31:0] eff_addr
);

    logic              sck_rise;
    logic              sck_fall;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              rd_start;
    logic              rd_active;

    bankreg_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .cs_n      (cs_n),
        .si        (si),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    bankreg_fsm #(.BANK_BITS(BANK_BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck_rise  (sck_rise),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .busy      (busy),
        .prog_err  (prog_err),
        .erase_err (erase_err),
        .bank_reg  (bank_reg),
        .armed     (armed),
        .rd_start  (rd_start),
        .rd_active (rd_active)
    );

    bankreg_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_start  (rd_start),
        .rd_active (rd_active),
        .sck_fall  (sck_fall),
        .bank_reg  (bank_reg),
        .so        (so)
    );

    bankreg_addr_map #(.BANK_BITS(BANK_BITS), .ADDR_W(24)) u_map (
        .bank_reg    (bank_reg),
        .cmd_addr    (cmd_addr),
        .ext_addr_en (ext_addr_en),
        .eff_addr    (eff_addr)
    );

    assign so_oe = ~cs_n;

endmodule

// File: rtl/bankreg_ctrl_sva.sv
module bankreg_ctrl_sva #(
    parameter int BANK_BITS = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       busy,
    input logic       prog_err,
    input logic       erase_err,
    input logic [7:0] bank_reg,
    input logic       armed
);

    localparam logic [7:0] KEEP_MASK = 8'h80 | 8'((1 << BANK_BITS) - 1);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_reg & ~KEEP_MASK) == 8'h00);

    p_ext_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> bank_reg[7] == $past(bank_reg[7]));

    p_arm_needs_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(!(busy || prog_err || erase_err)));

    p_err_blocks_legacy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (busy || prog_err || erase_err)) |=> $stable(bank_reg));

    p_hold_cs_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> $stable(bank_reg));

endmodule

bind bankreg_ctrl bankreg_ctrl_sva #(.BANK_BITS(BANK_BITS)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .busy      (busy),
    .prog_err  (prog_err),
    .erase_err (erase_err),
    .bank_reg  (bank_reg),
    .armed     (armed)
);

// File: tb/bankreg_ctrl_bench.sv
module bankreg_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        busy = 1'b0;
    logic        prog_err = 1'b0;
    logic        erase_err = 1'b0;
    logic [23:0] cmd_addr = 24'h123456;
    logic        so;
    logic        so_oe;
    logic [7:0]  bank_reg;
    logic        ext_addr_en;
    logic        armed;
    logic [31:0] eff_addr;

    int   checks = 0;
    int   failures = 0;
    bit   live = 1'b0;
    bit   done = 1'b0;
    logic [7:0] exp_bank = 8'h00;
    logic       exp_armed = 1'b0;
    logic [7:0] got;

    bankreg_ctrl u_bankreg_ctrl (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .busy(busy), .prog_err(prog_err), .erase_err(erase_err),
        .cmd_addr(cmd_addr), .so(so), .so_oe(so_oe), .bank_reg(bank_reg),
        .ext_addr_en(ext_addr_en), .armed(armed), .eff_addr(eff_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_addr();
        int hi;
        hi = exp_bank[7] ? 0 : (exp_bank % 4);
        return (hi * 32'h0100_0000) + cmd_addr;
    endfunction

    // Reference model compared on every clock
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (live && !done) begin
            chk(bank_reg === exp_bank, "R2 bank_reg per-cycle", {24'h0, bank_reg}, {24'h0, exp_bank});
            chk(armed === exp_armed, "R5 armed per-cycle", {31'h0, armed}, {31'h0, exp_armed});
            chk(ext_addr_en === exp_bank[7], "R4 ext_addr_en", {31'h0, ext_addr_en}, {31'h0, exp_bank[7]});
            chk(eff_addr === model_addr(), "R4 eff_addr", eff_addr, model_addr());
            chk(so_oe === !cs_n, "R3 so_oe", {31'h0, so_oe}, {31'h0, !cs_n});
        end
    end

    task automatic frame_start();
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic frame_end();
        @(negedge clk) sck = 1'b0;
        @(negedge clk) cs_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, output logic [7:0] rd);
        rd = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk) begin sck = 1'b0; si = b[i]; end
            @(negedge clk) sck = 1'b1;
            rd[i] = so;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] rd);
        send_bits(b, 8, rd);
    endtask

    // Complete arming frame; expectation depends on status inputs
    task automatic arm_frame();
        logic [7:0] d;
        frame_start();
        send_byte(8'hB9, d);
        if (exp_armed) exp_armed = 1'b0;
        frame_end();
        exp_armed = !(busy || prog_err || erase_err);
        idle(2);
    endtask

    task automatic bank_write(input logic [7:0] v);
        logic [7:0] d;
        frame_start();
        send_byte(8'h17, d);
        exp_armed = 1'b0;
        send_byte(v, d);
        exp_bank = v & 8'h83;
        frame_end();
        idle(2);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        idle(3);
        // R1: reset state
        chk(bank_reg === 8'h00, "R1 reset bank_reg", {24'h0, bank_reg}, 32'h0);
        chk(armed === 1'b0, "R1 reset armed", {31'h0, armed}, 32'h0);
        chk(so_oe === 1'b0 && so === 1'b0, "R1 reset so/so_oe", {30'h0, so_oe, so}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        live = 1'b1;
        idle(2);

        // R2: direct writes, including reserved bits
        bank_write(8'h81);
        chk(bank_reg === 8'h81, "R2 write 81h", {24'h0, bank_reg}, 32'h81);
        bank_write(8'hFF);
        chk(bank_reg === 8'h83, "R2 reserved masked", {24'h0, bank_reg}, 32'h83);
        bank_write(8'h7C);
        chk(bank_reg === 8'h00, "R2 only reserved bits", {24'h0, bank_reg}, 32'h0);
        busy = 1'b1;
        bank_write(8'h02);
        busy = 1'b0;
        chk(bank_reg === 8'h02, "R2 write while busy", {24'h0, bank_reg}, 32'h2);

        // R2: extra byte in same frame ignored
        frame_start();
        send_byte(8'h17, d);
        send_byte(8'h01, d);
        exp_bank = 8'h01;
        send_byte(8'h82, d);
        frame_end();
        idle(2);
        chk(bank_reg === 8'h01, "R2 second byte ignored", {24'h0, bank_reg}, 32'h1);

        // R4: address formation under both modes
        cmd_addr = 24'hABCDEF;
        idle(2);
        chk(eff_addr === 32'h01ABCDEF, "R4 bank high bits", eff_addr, 32'h01ABCDEF);
        bank_write(8'h83);
        chk(eff_addr === 32'h00ABCDEF, "R4 ext on", eff_addr, 32'h00ABCDEF);

        // R3: read two repeated bytes
        bank_write(8'h82);
        frame_start();
        send_byte(8'h16, d);
        send_byte(8'h00, d);
        chk(d === 8'h82, "R3 read first byte", {24'h0, d}, 32'h82);
        send_byte(8'h00, d);
        chk(d === 8'h82, "R3 read repeat", {24'h0, d}, 32'h82);
        frame_end();
        idle(2);
        chk(so === 1'b0 && so_oe === 1'b0, "R3 so idle", {30'h0, so_oe, so}, 32'h0);

        // R5/R6: arm then redirected write, second byte ignored
        bank_write(8'h81);
        arm_frame();
        chk(armed === 1'b1, "R5 armed after B9", {31'h0, armed}, 32'h1);
        frame_start();
        send_byte(8'h01, d);
        send_byte(8'hFE, d);
        exp_bank = 8'h82;
        exp_armed = 1'b0;
        send_byte(8'h01, d);
        frame_end();
        idle(2);
        chk(bank_reg === 8'h82, "R6 low bits loaded, bit7 kept", {24'h0, bank_reg}, 32'h82);
        chk(armed === 1'b0, "R6 disarmed", {31'h0, armed}, 32'h0);

        // R11: plain 01h does nothing
        frame_start();
        send_byte(8'h01, d);
        send_byte(8'h03, d);
        frame_end();
        idle(2);
        chk(bank_reg === 8'h82, "R11 unarmed 01h", {24'h0, bank_reg}, 32'h82);

        // R7: other command disarms and runs normally
        arm_frame();
        bank_write(8'h03);
        chk(bank_reg === 8'h03 && armed === 1'b0, "R7 17h after arm", {23'h0, armed, bank_reg}, 32'h3);
        arm_frame();
        frame_start();
        send_byte(8'h16, d);
        exp_armed = 1'b0;
        send_byte(8'h00, d);
        chk(d === 8'h03, "R7 16h after arm", {24'h0, d}, 32'h3);
        frame_end();
        idle(2);

        // R8: empty frame, short frame and truncated 01h frame disarm
        arm_frame();
        frame_start();
        frame_end();
        exp_armed = 1'b0;
        idle(2);
        chk(armed === 1'b0, "R8 empty frame", {31'h0, armed}, 32'h0);
        arm_frame();
        frame_start();
        send_bits(8'h01, 3, d);
        frame_end();
        exp_armed = 1'b0;
        idle(2);
        chk(armed === 1'b0, "R8 short frame", {31'h0, armed}, 32'h0);
        arm_frame();
        frame_start();
        send_byte(8'h01, d);
        send_bits(8'h00, 5, d);
        frame_end();
        exp_armed = 1'b0;
        idle(2);
        chk(armed === 1'b0 && bank_reg === 8'h03, "R8 truncated 01h", {23'h0, armed, bank_reg}, 32'h3);

        // R5: over-clocked arming frame
        frame_start();
        send_byte(8'hB9, d);
        send_bits(8'h00, 2, d);
        frame_end();
        idle(2);
        chk(armed === 1'b0, "R5 extra bits no arm", {31'h0, armed}, 32'h0);

        // R9: status flags block arming and the redirected write
        busy = 1'b1;
        arm_frame();
        busy = 1'b0;
        chk(armed === 1'b0, "R9 busy blocks arm", {31'h0, armed}, 32'h0);
        prog_err = 1'b1;
        arm_frame();
        prog_err = 1'b0;
        chk(armed === 1'b0, "R9 prog_err blocks arm", {31'h0, armed}, 32'h0);
        arm_frame();
        erase_err = 1'b1;
        frame_start();
        send_byte(8'h01, d);
        send_byte(8'h00, d);
        exp_armed = 1'b0;
        frame_end();
        erase_err = 1'b0;
        idle(2);
        chk(bank_reg === 8'h03 && armed === 1'b0, "R9 erase_err drops write", {23'h0, armed, bank_reg}, 32'h3);

        // R10/R12: aborted data byte
        frame_start();
        send_byte(8'h17, d);
        send_bits(8'h80, 5, d);
        frame_end();
        idle(4);
        chk(bank_reg === 8'h03, "R10 aborted byte", {24'h0, bank_reg}, 32'h3);
        chk(bank_reg === 8'h03, "R12 stable with cs high", {24'h0, bank_reg}, 32'h3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule